// File: doc/BRIEF.md
# Destructive-Read Core Memory Cycle Controller

This block sequences accesses to a word-organised storage array that behaves like magnetic core: reading a word wipes the location to zero, so every access is split into a read half-cycle followed by a write half-cycle. The write half-cycle puts back the word just read, stores fresh data for a write, or stores the word plus one when an indirect reference lands in a small auto-index window. The word seen during the access is held in a memory buffer register that the requester reads once the cycle finishes.

Two requesters share the array. One is a processor port that carries an address, a write flag, an indirect flag and write data. The other is an operator panel. The panel can load its address register from the switches. It can examine, which reads the word at that address. It can deposit, which writes the switch word there. Examine and deposit both step the panel address by one afterwards. A per-bit inhibit input and a stuck-inhibit input model the drivers that stop bits from being set, so that failure modes can be reproduced.

Top module: `core_cycle_ctrl`

## Requirements
- R1: After reset `busy`, `done`, `mb` and `mar` are all zero.
- R2: A processor read with `cpu_we`=0 returns the stored word in `mb` and restores it, so a second read of the same address returns the same word.
- R3: A processor write with `cpu_we`=1 stores `cpu_wdata` at `cpu_addr` and leaves that word in `mb`.
- R4: When a request is accepted at a clock edge, `busy` is high for the next two cycles. In the cycle after that, `busy` is low and `done` is high for one cycle. Requests raised while `busy` is high have no effect.
- R5: `pnl_exam` reads the word at `mar` into `mb`, restores it, and then sets `mar` to `mar`+1.
- R6: `pnl_dep` stores `pnl_sw` at `mar`, leaves it in `mb`, and then sets `mar` to `mar`+1.
- R7: A processor read with `cpu_ind`=1 at an address from 0010 to 0017 octal (8 to 15) writes back the read word plus one, and `mb` shows the incremented word. Any other read writes back the word unchanged.
- R8: Incrementing 7777 octal wraps to 0000. This applies both to the auto-index write-back and to `mar`.
- R9: A bit set in `inh_mask` during the write half-cycle is stored as zero, while `mb` still shows the unmasked word.
- R10: With `inh_stuck` high during the write half-cycle, the location is left all zeros, which shows that the read half-cycle cleared it.
- R11: When the block is idle, `pnl_load` takes precedence: it copies `pnl_sw` into `mar` without starting a cycle. Otherwise deposit wins over examine, and examine wins over a processor request. A request that loses is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | Processor access request, held until accepted |
| cpu_we | input | 1 | 1 = write `cpu_wdata`, 0 = read and restore |
| cpu_ind | input | 1 | Indirect reference (enables auto-index) |
| cpu_addr | input | 12 | Processor word address |
| cpu_wdata | input | 12 | Processor write data |
| pnl_load | input | 1 | Load `mar` from switches |
| pnl_exam | input | 1 | Examine word at `mar` |
| pnl_dep | input | 1 | Deposit switches at `mar` |
| pnl_sw | input | 12 | Panel switch word |
| inh_mask | input | 12 | Per-bit inhibit during write half-cycle |
| inh_stuck | input | 1 | Fault injection: all bits inhibited |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-cycle pulse after a cycle ends |
| mb | output | 12 | Memory buffer: word of the last cycle |
| mar | output | 12 | Panel memory address register |

## Verification
The bench first writes a known pattern into a small range of low addresses. It then mixes random reads, writes, examines, deposits, loads and inhibit settings, with indirect flags that sometimes fall inside the auto-index window and sometimes outside it. This shows whether each access picks the right write-back source. Directed cases cover the 7777 wrap, in both the address register and the auto-index path. Further cases cover a processor request made while busy, simultaneous panel and processor requests, and a stuck inhibit followed by a re-read. The last of these tells a correct restore apart from the destructive clear that sits beneath it.

// File: rtl/core_pkg.sv
package core_pkg;
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_READ  = 2'd1,
      PH_WRITE = 2'd2
   } phase_t;

   typedef enum logic [1:0] {
      SRC_CPU  = 2'd0,
      SRC_EXAM = 2'd1,
      SRC_DEP  = 2'd2
   } src_t;
endpackage

// File: rtl/core_req_arb.sv
module core_req_arb
   import core_pkg::*;
#(
   parameter bit PANEL_FIRST = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic idle,
   input  logic cpu_req,
   input  logic pnl_load,
   input  logic pnl_exam,
   input  logic pnl_dep,
   output logic start,
   output logic load_take,
   output src_t src
);
   always_comb begin
      start     = 1'b0;
      load_take = 1'b0;
      src       = SRC_CPU;
      if (idle) begin
         if (PANEL_FIRST) begin
            if (pnl_load) begin
               load_take = 1'b1;
            end else if (pnl_dep) begin
               start = 1'b1;
               src   = SRC_DEP;
            end else if (pnl_exam) begin
               start = 1'b1;
               src   = SRC_EXAM;
            end else if (cpu_req) begin
               start = 1'b1;
               src   = SRC_CPU;
            end
         end else begin
            if (cpu_req) begin
               start = 1'b1;
               src   = SRC_CPU;
            end else if (pnl_load) begin
               load_take = 1'b1;
            end else if (pnl_dep) begin
               start = 1'b1;
               src   = SRC_DEP;
            end else if (pnl_exam) begin
               start = 1'b1;
               src   = SRC_EXAM;
            end
         end
      end
   end

   // R11: load and cycle start never granted together, and only when idle
   p_single_grant_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (start || load_take) |-> (idle && $onehot0({start, load_take})));
endmodule

// File: rtl/core_cycle_seq.sv
module core_cycle_seq
   import core_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   start,
   output phase_t phase,
   output logic   busy,
   output logic   done
);
   phase_t phase_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         done    <= 1'b0;
      end else begin
         done <= (phase_q == PH_WRITE);
         unique case (phase_q)
            PH_IDLE:  if (start) phase_q <= PH_READ;
            PH_READ:  phase_q <= PH_WRITE;
            PH_WRITE: phase_q <= PH_IDLE;
            default:  phase_q <= PH_IDLE;
         endcase
      end
   end

   assign phase = phase_q;
   assign busy  = (phase_q != PH_IDLE);

   // R4: read half-cycle always followed by write half-cycle
   p_read_then_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_READ) |=> (phase_q == PH_WRITE));
   // R4: write half-cycle ends the cycle with a done pulse
   p_write_then_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_q == PH_WRITE) |=> (!busy && done));
endmodule

// File: rtl/core_wb_path.sv
module core_wb_path #(
   parameter int DW       = 12,
   parameter int AW       = 12,
   parameter int IDX_BASE = 8,
   parameter int IDX_SPAN = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_phase,
   input  logic [AW-1:0] addr,
   input  logic          is_write,
   input  logic          is_ind,
   input  logic [DW-1:0] new_data,
   input  logic [DW-1:0] rd_word,
   input  logic [DW-1:0] inh_mask,
   input  logic          inh_stuck,
   output logic [DW-1:0] wb_word,
   output logic [DW-1:0] store_word
);
   localparam int IDX_LAST = IDX_BASE + IDX_SPAN - 1;

   logic in_window;
   assign in_window = (int'(addr) >= IDX_BASE) && (int'(addr) <= IDX_LAST);

   always_comb begin
      if (is_write)
         wb_word = new_data;
      else if (is_ind && in_window)
         wb_word = rd_word + DW'(1);
      else
         wb_word = rd_word;
   end

   for (genvar b = 0; b < DW; b++) begin : g_drv
      assign store_word[b] = wb_word[b] & ~inh_mask[b] & ~inh_stuck;
   end

   // R10: a stuck inhibit lets no bit through during the write half-cycle
   p_stuck_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_phase && inh_stuck) |-> (store_word == '0));
   // R9: inhibited bits never reach the array
   p_inhibit_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_phase |-> ((store_word & inh_mask) == '0));
endmodule

// File: rtl/core_dr_array.sv
module core_dr_array #(
   parameter int DW = 12,
   parameter int AW = 12
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_en,
   input  logic          wr_en,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] cells [DEPTH];

   always_ff @(posedge clk) begin
      if (rd_en) begin
         rdata       <= cells[addr];
         cells[addr] <= '0;
      end else if (wr_en) begin
         cells[addr] <= wdata;
      end
   end

   // R10: a read leaves the addressed word at zero
   p_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> (cells[$past(addr)] == '0));
endmodule

// File: rtl/core_cycle_ctrl.sv
module core_cycle_ctrl
   import core_pkg::*;
#(
   parameter int DW          = 12,
   parameter int AW          = 12,
   parameter int IDX_BASE    = 8,
   parameter int IDX_SPAN    = 8,
   parameter bit PANEL_FIRST = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cpu_req,
   input  logic          cpu_we,
   input  logic          cpu_ind,
   input  logic [AW-1:0] cpu_addr,
   input  logic [DW-1:0] cpu_wdata,
   input  logic          pnl_load,
   input  logic          pnl_exam,
   input  logic          pnl_dep,
   input  logic [DW-1:0] pnl_sw,
   input  logic [DW-1:0] inh_mask,
   input  logic          inh_stuck,
   output logic          busy,
   output logic          done,
   output logic [DW-1:0] mb,
   output logic [AW-1:0] mar
);
   localparam int DEPTH = 1 << AW;

   if (DW < AW) begin : g_bad_width
      $error("switch word must be at least as wide as the address");
   end
   if (IDX_BASE + IDX_SPAN > DEPTH) begin : g_bad_window
      $error("auto-index window exceeds the address space");
   end
   if (IDX_SPAN < 1) begin : g_bad_span
      $error("auto-index window must hold at least one word");
   end

   logic          start, load_take;
   src_t          src, cur_src;
   phase_t        phase;
   logic [AW-1:0] cur_addr;
   logic [DW-1:0] cur_data;
   logic          cur_we, cur_ind;
   logic [DW-1:0] rd_word, wb_word, store_word;
   logic          panel_end;

   core_req_arb #(.PANEL_FIRST(PANEL_FIRST)) u_arb (
      .clk(clk), .rst_n(rst_n), .idle(!busy),
      .cpu_req(cpu_req), .pnl_load(pnl_load), .pnl_exam(pnl_exam), .pnl_dep(pnl_dep),
      .start(start), .load_take(load_take), .src(src)
   );

   core_cycle_seq u_seq (
      .clk(clk), .rst_n(rst_n), .start(start),
      .phase(phase), .busy(busy), .done(done)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_src  <= SRC_CPU;
         cur_addr <= '0;
         cur_data <= '0;
         cur_we   <= 1'b0;
         cur_ind  <= 1'b0;
      end else if (start) begin
         cur_src  <= src;
         cur_addr <= (src == SRC_CPU) ? cpu_addr : mar;
         cur_data <= (src == SRC_CPU) ? cpu_wdata : pnl_sw;
         cur_we   <= (src == SRC_CPU) ? cpu_we : (src == SRC_DEP);
         cur_ind  <= (src == SRC_CPU) && cpu_ind;
      end
   end

   core_dr_array #(.DW(DW), .AW(AW)) u_array (
      .clk(clk), .rst_n(rst_n),
      .rd_en(phase == PH_READ), .wr_en(phase == PH_WRITE),
      .addr(cur_addr), .wdata(store_word), .rdata(rd_word)
   );

   core_wb_path #(.DW(DW), .AW(AW), .IDX_BASE(IDX_BASE), .IDX_SPAN(IDX_SPAN)) u_wb (
      .clk(clk), .rst_n(rst_n), .wr_phase(phase == PH_WRITE),
      .addr(cur_addr), .is_write(cur_we), .is_ind(cur_ind),
      .new_data(cur_data), .rd_word(rd_word),
      .inh_mask(inh_mask), .inh_stuck(inh_stuck),
      .wb_word(wb_word), .store_word(store_word)
   );

   assign panel_end = (phase == PH_WRITE) && (cur_src != SRC_CPU);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mb  <= '0;
         mar <= '0;
      end else begin
         if (phase == PH_WRITE) mb <= wb_word;
         if (load_take)
            mar <= pnl_sw[AW-1:0];
         else if (panel_end)
            mar <= mar + AW'(1);
      end
   end

   // R5: panel address moves only on a load or at the end of a panel cycle
   p_mar_moves_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mar) |-> ($past(load_take) || $past(panel_end)));
   // R4: buffer register changes only as a cycle completes
   p_mb_on_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(mb) |-> done);
endmodule

// File: tb/core_cycle_ctrl_test.sv
module core_cycle_ctrl_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 0, cpu_we = 0, cpu_ind = 0;
   logic [11:0] cpu_addr = '0, cpu_wdata = '0;
   logic        pnl_load = 0, pnl_exam = 0, pnl_dep = 0;
   logic [11:0] pnl_sw = '0, inh_mask = '0;
   logic        inh_stuck = 0;
   logic        busy, done;
   logic [11:0] mb, mar;

   int n_chk = 0, n_fail = 0;
   bit finished = 0;
   logic [11:0] mdl [4096];
   logic [11:0] mar_m;

   always #5 clk = ~clk;

   core_cycle_ctrl uut (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_ind(cpu_ind),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .pnl_load(pnl_load), .pnl_exam(pnl_exam),
      .pnl_dep(pnl_dep), .pnl_sw(pnl_sw), .inh_mask(inh_mask), .inh_stuck(inh_stuck),
      .busy(busy), .done(done), .mb(mb), .mar(mar)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [11:0] wb_of(input bit we, input bit ind, input logic [11:0] a,
                                         input logic [11:0] d, input logic [11:0] rd);
      if (we) return d;
      if (ind && a >= 12'o10 && a <= 12'o17) return rd + 12'd1;
      return rd;
   endfunction

   // Runs one accepted cycle; request lines must already be set at this negedge.
   task automatic finish_cycle(input logic [11:0] exp_mb, input string req);
      @(negedge clk);
      cpu_req = 0; pnl_exam = 0; pnl_dep = 0;
      chk(busy === 1'b1, "R4 busy first", busy, 1);
      @(negedge clk);
      chk(busy === 1'b1, "R4 busy second", busy, 1);
      @(negedge clk);
      chk(busy === 1'b0 && done === 1'b1, "R4 done pulse", {busy, done}, 2'b01);
      chk(mb === exp_mb, req, mb, exp_mb);
      inh_mask = '0; inh_stuck = 0;
   endtask

   task automatic cpu_op(input bit we, input bit ind, input logic [11:0] a, input logic [11:0] d,
                         input logic [11:0] inh, input bit stuck, input string req);
      logic [11:0] wb;
      wb = wb_of(we, ind, a, d, mdl[a]);
      cpu_req = 1; cpu_we = we; cpu_ind = ind; cpu_addr = a; cpu_wdata = d;
      inh_mask = inh; inh_stuck = stuck;
      finish_cycle(wb, req);
      mdl[a] = stuck ? 12'd0 : (wb & ~inh);
   endtask

   task automatic pnl_op(input bit dep, input logic [11:0] sw, input logic [11:0] inh, input string req);
      logic [11:0] wb;
      wb = dep ? sw : mdl[mar_m];
      pnl_dep = dep; pnl_exam = !dep; pnl_sw = sw; inh_mask = inh;
      finish_cycle(wb, req);
      mdl[mar_m] = wb & ~inh;
      mar_m = mar_m + 12'd1;
      chk(mar === mar_m, dep ? "R6 mar step" : "R5 mar step", mar, mar_m);
   endtask

   task automatic load(input logic [11:0] sw);
      pnl_load = 1; pnl_sw = sw;
      @(negedge clk);
      pnl_load = 0;
      mar_m = sw;
      chk(mar === sw && busy === 1'b0, "R11 load", mar, sw);
   endtask

   task automatic summary();
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=0 expected=1");
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h0C0E5EED));
      mar_m = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      chk(busy === 0 && done === 0, "R1 flags", {busy, done}, 0);
      chk(mb === 0 && mar === 0, "R1 regs", {mb, mar}, 0);

      // R3 pre-fill low addresses with writes
      for (int i = 0; i < 32; i++) cpu_op(1, 0, 12'(i), 12'(i * 37 + 5), 0, 0, "R3 write");
      // R2 read restores
      cpu_op(0, 0, 12'd5, 0, 0, 0, "R2 read");
      cpu_op(0, 0, 12'd5, 0, 0, 0, "R2 reread");
      // R7 auto-index inside and at edges of window
      cpu_op(0, 1, 12'o10, 0, 0, 0, "R7 index 10");
      cpu_op(0, 1, 12'o17, 0, 0, 0, "R7 index 17");
      cpu_op(0, 1, 12'o20, 0, 0, 0, "R7 outside 20");
      cpu_op(0, 1, 12'o07, 0, 0, 0, "R7 outside 07");
      cpu_op(0, 0, 12'o10, 0, 0, 0, "R7 readback");
      cpu_op(0, 0, 12'o11, 0, 0, 0, "R7 direct no incr");
      // R8 auto-index wrap
      cpu_op(1, 0, 12'o12, 12'o7777, 0, 0, "R3 write 7777");
      cpu_op(0, 1, 12'o12, 0, 0, 0, "R8 index wrap");
      chk(mdl[12'o12] === 12'o0000, "R8 model wrap", mdl[12'o12], 0);
      cpu_op(0, 0, 12'o12, 0, 0, 0, "R8 wrapped value");
      // R9 per-bit inhibit
      cpu_op(1, 0, 12'd20, 12'o7777, 12'o0101, 0, "R9 mb unmasked");
      cpu_op(0, 0, 12'd20, 0, 0, 0, "R9 masked store");
      // R10 stuck inhibit leaves location cleared by the read
      cpu_op(0, 0, 12'd21, 0, 0, 1, "R10 stuck read");
      cpu_op(0, 0, 12'd21, 0, 0, 0, "R10 cleared word");
      // R5/R6 panel
      load(12'd3);
      pnl_op(0, 0, 0, "R5 exam");
      pnl_op(1, 12'o5252, 0, "R6 deposit");
      load(12'd4);
      pnl_op(0, 0, 0, "R6 exam deposited");
      // R8 mar wrap
      load(12'o7777);
      pnl_op(1, 12'o1234, 0, "R6 deposit top");
      chk(mar === 12'o0000, "R8 mar wrap", mar, 0);
      load(12'o7777);
      pnl_op(0, 0, 0, "R5 exam top");
      // R4 request while busy is ignored
      cpu_req = 1; cpu_we = 0; cpu_ind = 0; cpu_addr = 12'd6;
      @(negedge clk);
      cpu_req = 1; cpu_we = 1; cpu_addr = 12'd7; cpu_wdata = 12'o7070;
      @(negedge clk);
      cpu_req = 0;
      @(negedge clk);
      chk(done === 1 && mb === mdl[6], "R4 first cycle", mb, mdl[6]);
      cpu_op(0, 0, 12'd7, 0, 0, 0, "R4 busy request ignored");
      // R11 deposit beats cpu, load beats exam
      load(12'd9);
      pnl_dep = 1; pnl_sw = 12'o4321;
      cpu_req = 1; cpu_we = 1; cpu_ind = 0; cpu_addr = 12'd10; cpu_wdata = 12'o1111;
      finish_cycle(12'o4321, "R11 deposit wins");
      mdl[9] = 12'o4321; mar_m = 12'd10;
      cpu_op(0, 0, 12'd10, 0, 0, 0, "R11 cpu dropped");
      pnl_exam = 1;
      load(12'd2);
      pnl_exam = 0;
      @(negedge clk);
      chk(busy === 0 && done === 0, "R11 load no cycle", {busy, done}, 0);
      // random mix
      for (int k = 0; k < 400; k++) begin
         int kind;
         logic [11:0] a, d, inh;
         bit st;
         kind = $urandom_range(0, 4);
         a    = 12'($urandom_range(0, 31));
         d    = 12'($urandom);
         inh  = ($urandom_range(0, 7) == 0) ? 12'($urandom) : 12'd0;
         st   = ($urandom_range(0, 15) == 0);
         case (kind)
            0: cpu_op(0, $urandom_range(0, 1), a, 0, inh, st, "R7 random read");
            1: cpu_op(1, 0, a, d, inh, st, "R3 random write");
            2: begin load(a); pnl_op(0, 0, inh, "R5 random exam"); end
            3: begin load(a); pnl_op(1, d, inh, "R6 random deposit"); end
            default: cpu_op(0, 0, a, 0, 0, 0, "R2 random read");
         endcase
      end
      finished = 1;
      summary();
      $finish;
   end
endmodule